// File: doc/BRIEF.md
# Correlating Global-History Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps a shift register holding the outcomes of the most recent resolved branches from anywhere in the program. The front end presents a fetch address. The block joins the current outcome pattern to a few low address bits and uses the result to select one 2-bit saturating counter from a table. The upper bit of that counter is the prediction. The current history is returned with the prediction so that the front end can carry it along with the branch.

When the branch resolves, the back end returns the branch address, the real outcome and the history snapshot it was given at prediction time. The block moves the one counter that this snapshot and address select one step towards the outcome. It also shifts the outcome into the global history. Because the same address pairs with every possible history value, the recent branch pattern chooses between several counters for each branch. The table carries no tags, so different branches that share the low address bits share counters.

Setting the history length to zero turns the block into a plain address-indexed table of 2-bit counters.

Top module: `corr_branch_predictor`

## Requirements
- R1: Reset is synchronous and active low. It sets every counter to 1 (weakly not taken) and the global history to 0, so every address predicts not taken with `pred_hist` = 0 after reset.
- R2: `pred_taken` is 1 exactly when the counter at index {global history, `pred_pc[ADDR_BITS+1:2]`} holds 2 or 3. The history forms the upper index bits and the address bits form the lower index bits. `pred_hist` equals the current global history.
- R3: A resolve with `res_taken`=1 adds one to the selected counter. A resolve with `res_taken`=0 subtracts one from it.
- R4: A counter at 3 stays at 3 when a taken outcome arrives. A counter at 0 stays at 0 when a not-taken outcome arrives.
- R5: A resolve selects its counter with `res_hist` and `res_pc[ADDR_BITS+1:2]`, and ignores the current global history.
- R6: A resolve changes only the one selected counter. Counters for the same address under other history values, and counters for other addresses, keep their values.
- R7: On each resolve the history shifts left by one. `res_taken` enters bit 0 and the oldest bit is dropped. Without a resolve the history holds its value.
- R8: The table is untagged. Addresses that differ only in bits [1:0] or in bits above ADDR_BITS+1 share the same counters.
- R9: A prediction is a combinational read of the counters. A resolve becomes visible to predictions from the next clock cycle. A prediction made in the same cycle as a resolve sees the old counter value.
- R10: With HIST_BITS = 0 the index is `pc[ADDR_BITS+1:2]` alone, `pred_hist` reads 0 and `res_hist` is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pred_pc | input | PC_W | Address of the branch being predicted |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| pred_hist | output | max(HIST_BITS,1) | Global history snapshot to carry with the branch |
| res_valid | input | 1 | A branch resolves in this cycle |
| res_pc | input | PC_W | Address of the resolving branch |
| res_taken | input | 1 | Actual outcome, 1 = taken |
| res_hist | input | max(HIST_BITS,1) | History snapshot that was returned at prediction time |

## Verification
The embedded assertions check the following on every cycle:
- the history shift: the new bit enters at bit 0, older bits move up one place, and the history holds when there is no resolve;
- the single-step counter moves on every update;
- saturation at both ends of the counter.

The bench's scenarios are needed for the remaining behaviours:
- only the selected counter changes;
- the update is indexed by the returned snapshot rather than the live history;
- aliasing through the ignored address bits;
- the same-cycle read-before-write order;
- the zero-history variant.

The bench keeps its own arithmetic model of every counter and of the history. After each resolve it sweeps all address slots under the current history.

// File: rtl/cbp_pkg.sv
// Package: shared counter type and step function for the predictor.
// Assumes 2-bit counters; values 2 and 3 mean "predict taken".
package cbp_pkg;

    typedef enum logic [1:0] {
        CTR_STRONG_NT = 2'd0,
        CTR_WEAK_NT   = 2'd1,
        CTR_WEAK_T    = 2'd2,
        CTR_STRONG_T  = 2'd3
    } ctr_t;

    // Move a counter one step towards the outcome, saturating at both ends.
    function automatic ctr_t ctr_step(ctr_t cur, logic taken);
        if (taken) begin
            return (cur == CTR_STRONG_T) ? CTR_STRONG_T : ctr_t'(cur + 2'd1);
        end
        return (cur == CTR_STRONG_NT) ? CTR_STRONG_NT : ctr_t'(cur - 2'd1);
    endfunction

endpackage

// File: rtl/cbp_history.sv
// Global outcome history register.
// Shifts the resolved outcome into bit 0 when shift_en is high and drops the
// oldest bit. With HIST_BITS = 0 the output is tied to 0.
// Assumes a synchronous active-low reset that clears the history.
module cbp_history #(
    parameter int HIST_BITS = 2,
    parameter int HW        = (HIST_BITS > 0) ? HIST_BITS : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          shift_en,
    input  logic          shift_bit,
    output logic [HW-1:0] hist
);

    generate
        if (HIST_BITS == 0) begin : g_none
            logic unused_shift;
            assign unused_shift = shift_en ^ shift_bit ^ clk ^ rst_n;
            assign hist = '0;
        end else begin : g_reg
            logic [HIST_BITS-1:0] hist_q;

            // Shift register update: the outcome enters at bit 0.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    hist_q <= '0;
                end else if (shift_en) begin
                    if (HIST_BITS == 1) begin
                        hist_q <= shift_bit;
                    end else begin
                        hist_q <= {hist_q[HIST_BITS-2:0], shift_bit};
                    end
                end
            end

            assign hist = hist_q;

            assert_shift_in_R7: assert property (@(posedge clk) disable iff (!rst_n)
                shift_en |=> hist[0] == $past(shift_bit));

            assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
                !shift_en |=> $stable(hist));

            if (HIST_BITS > 1) begin : g_age
                assert_age_R7: assert property (@(posedge clk) disable iff (!rst_n)
                    shift_en |=> hist[HIST_BITS-1:1] == $past(hist[HIST_BITS-2:0]));
            end
        end
    endgenerate

endmodule

// File: rtl/cbp_index.sv
// Index former: joins the history (upper bits) with pc[ADDR_BITS+1:2]
// (lower bits). The history is left out when HIST_BITS = 0.
// Assumes PC_W > ADDR_BITS + 2. Purely combinational.
module cbp_index #(
    parameter int HIST_BITS = 2,
    parameter int ADDR_BITS = 4,
    parameter int PC_W      = 32,
    parameter int HW        = (HIST_BITS > 0) ? HIST_BITS : 1,
    parameter int IDX_W     = HIST_BITS + ADDR_BITS
) (
    input  logic [PC_W-1:0]  pc,
    input  logic [HW-1:0]    hist,
    output logic [IDX_W-1:0] idx
);

    logic unused_pc;
    assign unused_pc = ^{pc[PC_W-1:ADDR_BITS+2], pc[1:0]};

    generate
        if (HIST_BITS > 0) begin : g_corr
            assign idx = {hist[HIST_BITS-1:0], pc[ADDR_BITS+1:2]};
        end else begin : g_plain
            logic unused_hist;
            assign unused_hist = ^hist;
            assign idx = pc[ADDR_BITS+1:2];
        end
    endgenerate

endmodule

// File: rtl/cbp_counter_table.sv
// Table of 2-bit saturating counters.
// It has one combinational read port and one write port that applies a
// saturating step at the next clock edge.
// Assumes a synchronous active-low reset that sets every counter to 1.
module cbp_counter_table
    import cbp_pkg::*;
#(
    parameter int IDX_W = 6,
    parameter int DEPTH = 1 << IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_taken,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_taken
);

    ctr_t tbl [DEPTH];

    // Counter storage: reset every entry, then step only the addressed one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                tbl[i] <= CTR_WEAK_NT;
            end
        end else if (wr_en) begin
            tbl[wr_idx] <= ctr_step(tbl[wr_idx], wr_taken);
        end
    end

    // Read port: the prediction is the upper bit of the selected counter.
    always_comb begin
        rd_taken = tbl[rd_idx][1];
    end

    assert_step_up_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_taken && tbl[wr_idx] != CTR_STRONG_T)
        |=> tbl[$past(wr_idx)] == ctr_t'($past(tbl[wr_idx]) + 2'd1));

    assert_step_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_taken && tbl[wr_idx] != CTR_STRONG_NT)
        |=> tbl[$past(wr_idx)] == ctr_t'($past(tbl[wr_idx]) - 2'd1));

    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_taken && tbl[wr_idx] == CTR_STRONG_T)
        |=> tbl[$past(wr_idx)] == CTR_STRONG_T);

    assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_taken && tbl[wr_idx] == CTR_STRONG_NT)
        |=> tbl[$past(wr_idx)] == CTR_STRONG_NT);

endmodule

// File: rtl/corr_branch_predictor.sv
// Correlating direction predictor (top).
// The global history and the low address bits select one 2-bit counter for
// each prediction. A resolve steps the counter chosen by the returned history
// snapshot and shifts the outcome into the history.
// Assumes the caller returns the pred_hist value unchanged as res_hist.
// There are no tags, so aliasing is allowed.
module corr_branch_predictor #(
    parameter int HIST_BITS = 2,
    parameter int ADDR_BITS = 4,
    parameter int PC_W      = 32
) (
    input  logic                                     clk,
    input  logic                                     rst_n,
    input  logic [PC_W-1:0]                          pred_pc,
    output logic                                     pred_taken,
    output logic [((HIST_BITS > 0) ? HIST_BITS : 1)-1:0] pred_hist,
    input  logic                                     res_valid,
    input  logic [PC_W-1:0]                          res_pc,
    input  logic                                     res_taken,
    input  logic [((HIST_BITS > 0) ? HIST_BITS : 1)-1:0] res_hist
);

    localparam int HW    = (HIST_BITS > 0) ? HIST_BITS : 1;
    localparam int IDX_W = HIST_BITS + ADDR_BITS;

    logic [HW-1:0]    ghist;
    logic [IDX_W-1:0] rd_idx;
    logic [IDX_W-1:0] wr_idx;

    cbp_history #(.HIST_BITS(HIST_BITS), .HW(HW)) u_hist (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (res_valid),
        .shift_bit(res_taken),
        .hist     (ghist)
    );

    cbp_index #(.HIST_BITS(HIST_BITS), .ADDR_BITS(ADDR_BITS), .PC_W(PC_W),
                .HW(HW), .IDX_W(IDX_W)) u_rd_index (
        .pc  (pred_pc),
        .hist(ghist),
        .idx (rd_idx)
    );

    cbp_index #(.HIST_BITS(HIST_BITS), .ADDR_BITS(ADDR_BITS), .PC_W(PC_W),
                .HW(HW), .IDX_W(IDX_W)) u_wr_index (
        .pc  (res_pc),
        .hist(res_hist),
        .idx (wr_idx)
    );

    cbp_counter_table #(.IDX_W(IDX_W)) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_idx  (rd_idx),
        .rd_taken(pred_taken),
        .wr_en   (res_valid),
        .wr_idx  (wr_idx),
        .wr_taken(res_taken)
    );

    assign pred_hist = ghist;

endmodule

// File: tb/tb_corr_branch_predictor.sv
`timescale 1ns/1ps
// Bench: a 2-bit-history instance (dut) and a zero-history instance (dut0)
// share the same stimulus. Arithmetic models of both predict every output.
module tb_corr_branch_predictor;

    localparam int HB = 2;
    localparam int AB = 4;
    localparam int PW = 32;
    localparam int D2 = 1 << (HB + AB);
    localparam int NA = 1 << AB;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [PW-1:0] pred_pc = '0;
    logic [PW-1:0] res_pc = '0;
    logic res_valid = 1'b0;
    logic res_taken = 1'b0;
    logic [HB-1:0] res_hist = '0;
    logic pt2, pt0, ph0;
    logic [HB-1:0] ph2;

    corr_branch_predictor #(.HIST_BITS(HB), .ADDR_BITS(AB), .PC_W(PW)) dut (
        .clk(clk), .rst_n(rst_n), .pred_pc(pred_pc), .pred_taken(pt2),
        .pred_hist(ph2), .res_valid(res_valid), .res_pc(res_pc),
        .res_taken(res_taken), .res_hist(res_hist)
    );

    corr_branch_predictor #(.HIST_BITS(0), .ADDR_BITS(AB), .PC_W(PW)) dut0 (
        .clk(clk), .rst_n(rst_n), .pred_pc(pred_pc), .pred_taken(pt0),
        .pred_hist(ph0), .res_valid(res_valid), .res_pc(res_pc),
        .res_taken(res_taken), .res_hist(res_hist[0])
    );

    int total = 0;
    int bad = 0;
    bit done = 0;
    int m2 [D2];
    int m0 [NA];
    int gh = 0;
    logic [31:0] seed = 32'h1357_9bdf;

    function automatic int slot(logic [PW-1:0] pc);
        return int'((pc >> 2) & (NA - 1));
    endfunction

    function automatic int sat(int v);
        return (v < 0) ? 0 : ((v > 3) ? 3 : v);
    endfunction

    task automatic chk(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic rnd();
        seed ^= seed << 13;
        seed ^= seed >> 17;
        seed ^= seed << 5;
    endtask

    task automatic model_reset();
        for (int i = 0; i < D2; i++) m2[i] = 1;
        for (int i = 0; i < NA; i++) m0[i] = 1;
        gh = 0;
    endtask

    task automatic model_update(logic [PW-1:0] pc, bit t, int h);
        int i2;
        i2 = (h << AB) | slot(pc);
        m2[i2] = sat(m2[i2] + (t ? 1 : -1));
        m0[slot(pc)] = sat(m0[slot(pc)] + (t ? 1 : -1));
        gh = ((gh << 1) | int'(t)) & ((1 << HB) - 1);
    endtask

    // Compare both predictors' outputs for one address against the models.
    task automatic check_pc(logic [PW-1:0] pc, string tag);
        @(negedge clk);
        pred_pc = pc;
        #1;
        chk({tag, " pred"}, int'(pt2), int'(m2[(gh << AB) | slot(pc)] >= 2));
        chk({tag, " hist"}, int'(ph2), gh);
        chk({tag, " R10 pred"}, int'(pt0), int'(m0[slot(pc)] >= 2));
        chk({tag, " R10 hist"}, int'(ph0), 0);
    endtask

    task automatic sweep(string tag);
        for (int a = 0; a < NA; a++) check_pc(PW'(a << 2), tag);
    endtask

    task automatic resolve(logic [PW-1:0] pc, bit t, int h);
        @(negedge clk);
        res_valid = 1'b1;
        res_pc = pc;
        res_taken = t;
        res_hist = HB'(h);
        @(posedge clk);
        #1;
        res_valid = 1'b0;
        model_update(pc, t, h);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        rst_n = 1'b1;
        model_reset();
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: run hung actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [PW-1:0] p;
        model_reset();
        do_reset();
        // R1: every slot predicts not taken with zero history.
        sweep("R1 reset");

        // R3, R4: saturate one counter high, then low, under history 3.
        p = 32'h0000_0040;
        for (int k = 0; k < 6; k++) resolve(p, 1'b1, 3);
        check_pc(p, "R4 sat high");
        for (int k = 0; k < 5; k++) resolve(p, 1'b0, 3);
        sweep("R3 R6 after down");
        resolve(32'h0000_0080, 1'b1, 0);
        resolve(32'h0000_0080, 1'b1, 0);
        check_pc(p, "R4 sat low");

        // R5: train with a snapshot that differs from the live history.
        resolve(32'h0000_0010, 1'b1, 1);
        resolve(32'h0000_0010, 1'b1, 1);
        sweep("R5 snapshot index");

        // R8: aliasing through the ignored address bits.
        for (int k = 0; k < 3; k++) resolve(32'hABC0_0027, 1'b1, gh);
        check_pc(32'h0000_0024, "R8 alias");
        check_pc(32'h5550_0026, "R8 alias");

        // R9: a prediction in the same cycle as a resolve sees the old value.
        @(negedge clk);
        pred_pc = 32'h0000_0030;
        res_valid = 1'b1;
        res_pc = 32'h0000_0030;
        res_taken = 1'b1;
        res_hist = HB'(gh);
        #1;
        chk("R9 same cycle old", int'(pt2),
            int'(m2[(gh << AB) | slot(32'h30)] >= 2));
        @(posedge clk);
        #1;
        res_valid = 1'b0;
        model_update(32'h0000_0030, 1'b1, gh);
        sweep("R9 R7 next cycle");

        // R2 R3 R6 R7 R10: pseudo-random resolves, full sweep after each.
        for (int n = 0; n < 300; n++) begin
            rnd();
            resolve({seed[31:8], seed[7:0]}, seed[11] ^ seed[3], int'(seed[21:20]));
            sweep("R2 R6 R7 random");
        end

        // R1: reset after training restores the initial state.
        do_reset();
        sweep("R1 re-reset");

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule